// File: doc/BRIEF.md
# Dual Prescaled Timebase Counters

This block keeps two free-running up-counters that serve as the shared time reference for capture and compare logic elsewhere on the chip. The first timebase always runs from the system clock. Its rate is set by a coarse divider (fast or slow) followed by a binary divider. A forced divide-by-two mode overrides both dividers.

The second timebase can run from its own prescaled copy of the system clock. It can also take its rate from an external clock pin, in one of two ways: the pin's active edges clock the counter directly, or the pin's active level gates the prescaled system-clock ticks. The external pin is resynchronised with two flops before use, and an edge detector turns it into single-cycle enables. A stop request freezes both counters and both prescalers, and a registered acknowledge confirms the freeze.

All configuration arrives as plain inputs from a host register. The block drives only the two count values and the acknowledge.

Top module: `dual_timebase`

## Requirements
- R1: During and right after reset, both counts are zero and `stop_ack` is low.
- R2: With `tb1_fast_sel`=0 and `tb1_div2_force`=0, timebase 1 advances once every 32·2^c system clocks, where c is the value of `tb1_div_code` (00→32, 01→64, 10→128, 11→256). It never advances by more than one per clock.
- R3: With `tb1_fast_sel`=1 and `tb1_div2_force`=0, timebase 1 advances once every 4·2^c system clocks (00→4, 01→8, 10→16, 11→32).
- R4: With `tb1_div2_force`=1, timebase 1 advances every 2 system clocks, whatever `tb1_fast_sel` and `tb1_div_code` hold.
- R5: A clock edge that first sees a changed value on `{tb1_div2_force, tb1_fast_sel, tb1_div_code}` (or on `tb2_div_code` for timebase 2) clears that prescaler with no count. The next advance then comes exactly one full period later.
- R6: With `tb2_ext_sel`=0, timebase 2 advances once every 8·2^c system clocks, where c is the value of `tb2_div_code` (00→8, 01→16, 10→32, 11→64).
- R7: With `tb2_ext_sel`=1, `tb2_gate_mode`=0 and `tb2_falling`=0, timebase 2 advances once per rising edge of `ext_clk_pin`. The advance lands on the third clock edge that samples the new pin level. Pin edges are at least nine clocks apart.
- R8: With `tb2_falling`=1 in edge mode, only falling edges of `ext_clk_pin` advance timebase 2.
- R9: With `tb2_ext_sel`=1 and `tb2_gate_mode`=1, timebase 2 counts the ticks of its prescaler only while the synchronised pin is at its active level: high when `tb2_falling`=0, low when it is 1. The prescaler keeps running while the pin is inactive.
- R10: While `stop_req` is high, both counts and both prescalers hold their values. `stop_ack` follows `stop_req` one clock later.
- R11: Each count wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb1_fast_sel | input | 1 | Timebase 1 coarse divider: 1 = divide by 4, 0 = divide by 32 |
| tb1_div_code | input | 2 | Timebase 1 binary divider code (1, 2, 4, 8) |
| tb1_div2_force | input | 1 | Force timebase 1 to advance every 2 clocks |
| tb2_ext_sel | input | 1 | Timebase 2 uses the external pin |
| tb2_gate_mode | input | 1 | With the external pin selected: 1 = gate, 0 = clock |
| tb2_falling | input | 1 | External pin polarity: 1 = falling edge / low level |
| tb2_div_code | input | 2 | Timebase 2 prescaler code (8, 16, 32, 64 clocks) |
| ext_clk_pin | input | 1 | External clock/gate pin, asynchronous |
| stop_req | input | 1 | Freeze both timebases |
| tb1_count | output | CW | Timebase 1 value |
| tb2_count | output | CW | Timebase 2 value |
| stop_ack | output | 1 | Registered freeze acknowledge |

## Verification
The bench goes after these cases:
- **Divider changes in the middle of a period.** A design that kept the old prescaler phase would advance early or late after the change.
- **The forced divide-by-two with every divider code.** A design that let the divider fields leak through would run at the wrong rate.
- **Edge polarity and gate level.** A design that swapped them would count on the wrong transition, or count while the gate pin is inactive.
- **Stop windows.** A design that froze only the counters and not the prescalers would advance on the first clock after release.
- **Counter wrap.** A reference model compares counts and acknowledge on every cycle, so an off-by-one period or a missing synchroniser stage shows up as a one-cycle mismatch.

// File: rtl/dual_timebase.sv
module dual_timebase #(
  parameter int CW       = 16,
  parameter int FAST_LOG = 2,
  parameter int SLOW_LOG = 5,
  parameter int TB2_LOG  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb1_fast_sel,
  input  logic [1:0]    tb1_div_code,
  input  logic          tb1_div2_force,
  input  logic          tb2_ext_sel,
  input  logic          tb2_gate_mode,
  input  logic          tb2_falling,
  input  logic [1:0]    tb2_div_code,
  input  logic          ext_clk_pin,
  input  logic          stop_req,
  output logic [CW-1:0] tb1_count,
  output logic [CW-1:0] tb2_count,
  output logic          stop_ack
);
  localparam int PW1 = SLOW_LOG + 3;
  localparam int PW2 = TB2_LOG + 3;
  localparam int SW1 = $clog2(PW1 + 1);
  localparam int SW2 = $clog2(PW2 + 1);

  logic [PW1-1:0] p1;
  logic [PW2-1:0] p2;
  logic [3:0]     cfg1_q;
  logic [1:0]     cfg2_q;
  logic [2:0]     sync_q;
  logic [SW1-1:0] sh1;
  logic [SW2-1:0] sh2;
  logic [PW1-1:0] last1;
  logic [PW2-1:0] last2;
  logic [3:0]     cfg1;
  logic chg1, chg2, tick1, tick2, act_edge, act_lvl, inc2;

  assign cfg1  = {tb1_div2_force, tb1_fast_sel, tb1_div_code};
  assign sh1   = tb1_div2_force ? SW1'(1)
               : SW1'(tb1_fast_sel ? FAST_LOG : SLOW_LOG) + SW1'(tb1_div_code);
  assign sh2   = SW2'(TB2_LOG) + SW2'(tb2_div_code);
  assign last1 = {PW1{1'b1}} >> (SW1'(PW1) - sh1);
  assign last2 = {PW2{1'b1}} >> (SW2'(PW2) - sh2);

  assign chg1  = cfg1 != cfg1_q;
  assign chg2  = tb2_div_code != cfg2_q;
  assign tick1 = !chg1 && (p1 == last1);
  assign tick2 = !chg2 && (p2 == last2);

  assign act_edge = tb2_falling ? (!sync_q[1] && sync_q[2]) : (sync_q[1] && !sync_q[2]);
  assign act_lvl  = sync_q[1] ^ tb2_falling;
  assign inc2     = tb2_ext_sel ? (tb2_gate_mode ? (tick2 && act_lvl) : act_edge) : tick2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1        <= '0;
      p2        <= '0;
      cfg1_q    <= '0;
      cfg2_q    <= '0;
      sync_q    <= '0;
      tb1_count <= '0;
      tb2_count <= '0;
      stop_ack  <= 1'b0;
    end else begin
      cfg1_q   <= cfg1;
      cfg2_q   <= tb2_div_code;
      sync_q   <= {sync_q[1:0], ext_clk_pin};
      stop_ack <= stop_req;
      if (chg1)           p1 <= '0;
      else if (!stop_req) p1 <= tick1 ? '0 : p1 + 1'b1;
      if (chg2)           p2 <= '0;
      else if (!stop_req) p2 <= tick2 ? '0 : p2 + 1'b1;
      if (!stop_req && tick1) tb1_count <= tb1_count + 1'b1;
      if (!stop_req && inc2)  tb2_count <= tb2_count + 1'b1;
    end
  end
endmodule

// File: rtl/dual_timebase_chk.sv
module dual_timebase_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tb1_div2_force,
  input logic          stop_req,
  input logic [CW-1:0] tb1_count,
  input logic [CW-1:0] tb2_count,
  input logic          stop_ack
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_hold_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> ($stable(tb1_count) && $stable(tb2_count)));

  assert_ack_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> stop_ack);

  assert_ack_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |=> !stop_ack);

  // R11 wrap is also a single step modulo 2^CW
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (CW'(tb1_count - $past(tb1_count)) <= CW'(1)));

  assert_div2_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tb1_div2_force && $past(tb1_div2_force) && (tb1_count != $past(tb1_count)))
      |=> (tb1_count == $past(tb1_count)));
endmodule

bind dual_timebase dual_timebase_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb1_div2_force(tb1_div2_force), .stop_req(stop_req),
  .tb1_count(tb1_count), .tb2_count(tb2_count), .stop_ack(stop_ack));

// File: tb/test_dual_timebase.sv
module test_dual_timebase;
  localparam int CW  = 10;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 0, force2 = 0, ext = 0, gate = 0, fall = 0, pin = 0, stop = 0;
  logic [1:0] code1 = 0, code2 = 0;
  logic [CW-1:0] tb1, tb2;
  logic ack;

  always #10 clk = ~clk;

  dual_timebase #(.CW(CW)) i_dual_timebase (
    .clk(clk), .rst_n(rst_n), .tb1_fast_sel(fast), .tb1_div_code(code1),
    .tb1_div2_force(force2), .tb2_ext_sel(ext), .tb2_gate_mode(gate),
    .tb2_falling(fall), .tb2_div_code(code2), .ext_clk_pin(pin),
    .stop_req(stop), .tb1_count(tb1), .tb2_count(tb2), .stop_ack(ack));

  int checks = 0, fails = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  // reference model
  int m_p1, m_p2, m_tb1, m_tb2;
  bit [3:0] m_cfg1;
  bit [1:0] m_cfg2;
  bit m_a, m_b, m_c, m_ack;
  always @(posedge clk or negedge rst_n) begin
    int l1, l2;
    bit c1, c2, t1, t2, ae, lvl, inc2;
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_tb1 = 0; m_tb2 = 0; m_cfg1 = 0; m_cfg2 = 0;
      m_a = 0; m_b = 0; m_c = 0; m_ack = 0;
    end else begin
      l1 = force2 ? 2 : ((fast ? 4 : 32) << code1);
      l2 = 8 << code2;
      c1 = ({force2, fast, code1} != m_cfg1);
      c2 = (code2 != m_cfg2);
      t1 = !c1 && (m_p1 == l1 - 1);
      t2 = !c2 && (m_p2 == l2 - 1);
      ae = fall ? (!m_b && m_c) : (m_b && !m_c);
      lvl = fall ? !m_b : m_b;
      inc2 = ext ? (gate ? (t2 && lvl) : ae) : t2;
      if (!stop && t1)   m_tb1 = (m_tb1 + 1) % MOD;
      if (!stop && inc2) m_tb2 = (m_tb2 + 1) % MOD;
      if (c1) m_p1 = 0; else if (!stop) m_p1 = t1 ? 0 : m_p1 + 1;
      if (c2) m_p2 = 0; else if (!stop) m_p2 = t2 ? 0 : m_p2 + 1;
      m_cfg1 = {force2, fast, code1};
      m_cfg2 = code2;
      m_c = m_b; m_b = m_a; m_a = pin;
      m_ack = stop;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk({cur_req, " tb1 vs model"}, int'(tb1), m_tb1);
    chk({cur_req, " tb2 vs model"}, int'(tb2), m_tb2);
    chk({cur_req, " ack vs model"}, int'(ack), int'(m_ack));
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // apply already done at a negedge; expect n periods of length l to give +n
  task automatic periods1(string req, int l, int n);
    int base;
    wt(1); base = int'(tb1);
    wt(l * n - 1);
    chk({req, " early"}, int'(tb1), (base + n - 1) % MOD);
    wt(1);
    chk(req, int'(tb1), (base + n) % MOD);
  endtask

  task automatic periods2(string req, int l, int n);
    int base;
    wt(1); base = int'(tb2);
    wt(l * n);
    chk(req, int'(tb2), (base + n) % MOD);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pin = 1; wt(10);
      pin = 0; wt(10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int base, base2;
    bit seen;
    wt(3);
    chk("R1 tb1 in reset", int'(tb1), 0);
    chk("R1 tb2 in reset", int'(tb2), 0);
    chk("R1 ack in reset", int'(ack), 0);
    rst_n = 1;
    wt(1);
    chk("R1 tb1 after reset", int'(tb1), 0);
    chk("R1 ack after reset", int'(ack), 0);
    cmp_en = 1;

    cur_req = "R2";
    for (int k = 1; k <= 4; k++) begin
      code1 = 2'(k % 4);
      periods1("R2 slow divider", 32 << (k % 4), 3);
    end

    cur_req = "R3";
    fast = 1;
    for (int k = 0; k < 4; k++) begin
      code1 = 2'(k);
      periods1("R3 fast divider", 4 << k, 3);
    end

    cur_req = "R4";
    force2 = 1; code1 = 2;
    periods1("R4 forced div2 fast", 2, 10);
    fast = 0; code1 = 3;
    periods1("R4 forced div2 slow code", 2, 10);

    cur_req = "R5";
    force2 = 0; code1 = 0;
    wt(21);
    code1 = 1;
    periods1("R5 restart on change", 64, 1);

    cur_req = "R6";
    for (int k = 1; k <= 4; k++) begin
      code2 = 2'(k % 4);
      periods2("R6 tb2 internal", 8 << (k % 4), 3);
    end

    cur_req = "R7";
    ext = 1; gate = 0; fall = 0;
    wt(4); base = int'(tb2);
    pulses(5);
    chk("R7 rising edges", int'(tb2), (base + 5) % MOD);

    cur_req = "R8";
    fall = 1;
    wt(4); base = int'(tb2);
    pulses(4);
    chk("R8 falling edges", int'(tb2), (base + 4) % MOD);
    pin = 1; wt(10);
    chk("R8 rising ignored", int'(tb2), (base + 4) % MOD);
    pin = 0; wt(10);
    chk("R8 falling counted", int'(tb2), (base + 5) % MOD);

    cur_req = "R9";
    gate = 1; fall = 0; code2 = 0;
    wt(4); base = int'(tb2);
    wt(40);
    chk("R9 gate inactive low", int'(tb2), base);
    pin = 1; wt(80);
    chk("R9 gate active counts", ((int'(tb2) - base + MOD) % MOD >= 8) ? 1 : 0, 1);
    fall = 1;
    wt(4); base = int'(tb2);
    wt(40);
    chk("R9 active-low gate held by high pin", int'(tb2), base);
    pin = 0;

    cur_req = "R10";
    ext = 0; gate = 0; fall = 0; force2 = 1;
    wt(5);
    stop = 1;
    wt(1);
    chk("R10 ack raised", int'(ack), 1);
    base = int'(tb1); base2 = int'(tb2);
    wt(30);
    chk("R10 tb1 frozen", int'(tb1), base);
    chk("R10 tb2 frozen", int'(tb2), base2);
    stop = 0;
    wt(1);
    chk("R10 ack dropped", int'(ack), 0);
    wt(10);
    chk("R10 tb1 resumes", int'(tb1), (base + 5) % MOD);

    cur_req = "R11";
    seen = 0;
    for (int i = 0; i < 2 * MOD + 50; i++) begin
      base = int'(tb1);
      wt(1);
      if (base == MOD - 1 && int'(tb1) == 0) seen = 1;
    end
    chk("R11 tb1 wrapped to zero", int'(seen), 1);

    cmp_en = 0;
    report();
  end
endmodule